// File: doc/BRIEF.md
# Power Mode Transition Controller

This block tracks which clocked operating mode a small processor is running in and decides what a sleep request does. Three execution modes exist: high-speed, medium-speed (the fast clock divided down), and sub-active (the slow sub-clock). Four control bits are sampled together with the sleep request. They decide whether the request is a direct switch of clock domain, during which the processor keeps executing, or an ordinary halt.

Going from high-speed to sub-active takes effect on the next clock. Going from sub-active to high-speed first waits out an oscillator settling time chosen by a 3-bit select. The processor keeps running on the sub-clock during that wait. When either direct switch completes, the block raises a one-cycle interrupt request. Any other sleep request halts the processor until a wake input arrives.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Synchronous reset gives mode = 0 (high-speed), with cpu_halt, xfer_irq and sel_sub_clk all low.
- R2: The mode encoding is 0 = high-speed, 1 = medium-speed, 2 = sub-active, and 3 is never output. While the fast domain is active, div_en = 1 gives mode 1 with sel_div_clk = 1, and div_en = 0 gives mode 0 with sel_div_clk = 0.
- R3: In mode 0, a sleep_req with stby_sel = 1, lowspd_sel = 1, dt_en = 1 and psc_sel = 1 gives mode 2 with sel_sub_clk = 1 on the next cycle.
- R4: In mode 2, a sleep_req with stby_sel = 1, lowspd_sel = 0, dt_en = 1 and psc_sel = 1 leaves mode at 2 for 2^(3+settle_sel) - 1 further cycles. Mode becomes 0 and sel_sub_clk drops exactly 2^(3+settle_sel) cycles after the edge that took the request (8 cycles for code 0, up to 1024 for code 7).
- R5: cpu_halt stays low throughout a direct transition, including the whole settling wait.
- R6: xfer_irq is high for exactly one cycle: the first cycle in which a completed direct transition shows its new mode. It stays low at all other times.
- R7: A sleep_req with dt_en = 0 raises cpu_halt on the next cycle and leaves the mode unchanged, even when the other three bits are 1.
- R8: A sleep_req with dt_en = 1 but no matching combination (standby or prescaler bit 0, low-speed bit wrong for the current mode, or a request made in mode 1) raises cpu_halt and leaves the mode unchanged.
- R9: While halted, a wake pulse drops cpu_halt on the next cycle, and further sleep requests are ignored. Outside the halt, a wake pulse has no effect.
- R10: A sleep_req that arrives during a settling wait is ignored: cpu_halt stays low and the completion cycle does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Sleep request strobe |
| wake | input | 1 | Wake strobe that ends a halt |
| stby_sel | input | 1 | Standby select control bit |
| lowspd_sel | input | 1 | Low-speed select control bit |
| dt_en | input | 1 | Direct-transition enable |
| psc_sel | input | 1 | Prescaler select control bit |
| settle_sel | input | 3 | Settling-time code |
| div_en | input | 1 | Selects the divided fast clock (medium-speed) |
| mode | output | 2 | Current mode: 0 high, 1 medium, 2 sub-active |
| cpu_halt | output | 1 | Stops instruction execution |
| sel_sub_clk | output | 1 | Processor runs from the sub-clock |
| sel_div_clk | output | 1 | Processor runs from the divided fast clock |
| xfer_irq | output | 1 | Direct-transition interrupt request pulse |

## Verification
The bench measures the settling wait edge by edge for the shortest code, a middle code and the longest code. An off-by-one in the down-counter would switch the mode one cycle early or late, and a wrong shift would miss the wait length altogether. It drives a bogus sleep request in the middle of a wait, which a design without a guard would turn into a halt or a restart of the wait. Each control bit is flipped on its own, and requests are made from medium-speed mode, because a decoder that skipped any term would take a direct switch where a halt is due. Wake pulses are sent while running and extra sleep requests while halted, which catches a design that let either one leak through.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_HIGH = 2'd0,
    MODE_MED  = 2'd1,
    MODE_SUB  = 2'd2
  } pmc_mode_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HALT   = 2'd2
  } pmc_state_e;
endpackage

// File: rtl/pmc_req_decode.sv
module pmc_req_decode (
  input  logic in_sub,
  input  logic in_div,
  input  logic sleep_req,
  input  logic stby_sel,
  input  logic lowspd_sel,
  input  logic dt_en,
  input  logic psc_sel,
  output logic go_down,
  output logic go_up,
  output logic go_halt
);
  logic common_ok;

  // Shared terms of both direct switches; the low-speed bit picks the direction.
  assign common_ok = stby_sel && dt_en && psc_sel;

  always_comb begin
    go_down = sleep_req && common_ok && lowspd_sel && !in_sub && !in_div;
    go_up   = sleep_req && common_ok && !lowspd_sel && in_sub;
    go_halt = sleep_req && !go_down && !go_up;
  end
endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 3,
  localparam int MAX_LOG2 = BASE_LOG2 + (1 << SEL_W) - 1,
  localparam int CNT_W    = MAX_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  output logic             busy,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  // Wait length is a power of two: 2^(BASE_LOG2 + code).
  function automatic logic [CNT_W-1:0] settle_len(input logic [SEL_W-1:0] code);
    return CNT_W'(1) << (BASE_LOG2 + int'(code));
  endfunction

  assign expire = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load && !busy) begin
      busy <= 1'b1;
      cnt  <= settle_len(sel) - CNT_W'(1);
    end else if (expire) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic             wake,
  input  logic             stby_sel,
  input  logic             lowspd_sel,
  input  logic             dt_en,
  input  logic             psc_sel,
  input  logic [SEL_W-1:0] settle_sel,
  input  logic             div_en,
  output logic [1:0]       mode,
  output logic             cpu_halt,
  output logic             sel_sub_clk,
  output logic             sel_div_clk,
  output logic             xfer_irq
);
  pmc_state_e state;
  logic       sub_r;
  logic       irq_r;

  // Named internal events, brought out for the checker.
  logic ev_direct_down;
  logic ev_direct_up;
  logic ev_halt_enter;
  logic ev_settle_done;
  logic dec_down, dec_up, dec_halt;
  logic tmr_busy;

  pmc_req_decode u_dec (
    .in_sub     (sub_r),
    .in_div     (div_en),
    .sleep_req  (sleep_req),
    .stby_sel   (stby_sel),
    .lowspd_sel (lowspd_sel),
    .dt_en      (dt_en),
    .psc_sel    (psc_sel),
    .go_down    (dec_down),
    .go_up      (dec_up),
    .go_halt    (dec_halt)
  );

  // Requests count only while running; settling and halt ignore them.
  assign ev_direct_down = (state == ST_RUN) && dec_down;
  assign ev_direct_up   = (state == ST_RUN) && dec_up;
  assign ev_halt_enter  = (state == ST_RUN) && dec_halt;

  pmc_settle_timer #(
    .SEL_W     (SEL_W),
    .BASE_LOG2 (BASE_LOG2)
  ) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load   (ev_direct_up),
    .sel    (settle_sel),
    .busy   (tmr_busy),
    .expire (ev_settle_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RUN;
      sub_r <= 1'b0;
      irq_r <= 1'b0;
    end else begin
      irq_r <= 1'b0;
      unique case (state)
        ST_RUN: begin
          if (ev_direct_down) begin
            sub_r <= 1'b1;
            irq_r <= 1'b1;
          end else if (ev_direct_up) begin
            state <= ST_SETTLE;
          end else if (ev_halt_enter) begin
            state <= ST_HALT;
          end
        end
        ST_SETTLE: begin
          if (ev_settle_done) begin
            sub_r <= 1'b0;
            irq_r <= 1'b1;
            state <= ST_RUN;
          end
        end
        ST_HALT: begin
          if (wake) state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    if (sub_r)       mode = MODE_SUB;
    else if (div_en) mode = MODE_MED;
    else             mode = MODE_HIGH;
  end

  assign cpu_halt    = (state == ST_HALT);
  assign sel_sub_clk = sub_r;
  assign sel_div_clk = !sub_r && div_en;
  assign xfer_irq    = irq_r;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       cpu_halt,
  input logic       sel_sub_clk,
  input logic       xfer_irq,
  input logic       ev_direct_down,
  input logic       ev_direct_up,
  input logic       ev_halt_enter,
  input logic       ev_settle_done,
  input logic       tmr_busy
);
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode != 2'd3); // R2

  AST_DOWN_TAKES: assert property (@(posedge clk) disable iff (rst)
    ev_direct_down |=> (mode == 2'd2) && sel_sub_clk && xfer_irq); // R3

  AST_UP_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    ev_settle_done |=> (mode != 2'd2) && !sel_sub_clk && xfer_irq); // R4

  AST_NO_HALT_SETTLE: assert property (@(posedge clk) disable iff (rst)
    tmr_busy |-> !cpu_halt); // R5

  AST_HOLD_SUB_SETTLE: assert property (@(posedge clk) disable iff (rst)
    ev_direct_up |=> (mode == 2'd2) && !cpu_halt); // R5

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    xfer_irq |=> !xfer_irq); // R6

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ev_halt_enter |=> cpu_halt); // R8

  AST_SETTLE_EXCL: assert property (@(posedge clk) disable iff (rst)
    tmr_busy |-> !ev_halt_enter && !ev_direct_down); // R10
endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .mode           (mode),
  .cpu_halt       (cpu_halt),
  .sel_sub_clk    (sel_sub_clk),
  .xfer_irq       (xfer_irq),
  .ev_direct_down (ev_direct_down),
  .ev_direct_up   (ev_direct_up),
  .ev_halt_enter  (ev_halt_enter),
  .ev_settle_done (ev_settle_done),
  .tmr_busy       (tmr_busy)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_req = 1'b0, wake = 1'b0;
  logic       stby_sel = 1'b0, lowspd_sel = 1'b0, dt_en = 1'b0, psc_sel = 1'b0;
  logic [2:0] settle_sel = 3'd0;
  logic       div_en = 1'b0;
  logic [1:0] mode;
  logic       cpu_halt, sel_sub_clk, sel_div_clk, xfer_irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake(wake),
    .stby_sel(stby_sel), .lowspd_sel(lowspd_sel), .dt_en(dt_en), .psc_sel(psc_sel),
    .settle_sel(settle_sel), .div_en(div_en), .mode(mode), .cpu_halt(cpu_halt),
    .sel_sub_clk(sel_sub_clk), .sel_div_clk(sel_div_clk), .xfer_irq(xfer_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_bits(input logic s, input logic l, input logic d, input logic p);
    stby_sel = s; lowspd_sel = l; dt_en = d; psc_sel = p;
  endtask

  // Drive a one-cycle request; returns one negedge after the acting edge.
  task automatic pulse_sleep();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 mode", mode, 0);
    check("R1 halt", cpu_halt, 0);
    check("R1 irq", xfer_irq, 0);
    check("R1 sub", sel_sub_clk, 0);
  endtask

  task automatic t_medium();
    do_reset();
    div_en = 1'b1; @(negedge clk);
    check("R2 medium mode", mode, 1);
    check("R2 div sel", sel_div_clk, 1);
    // request from medium with all bits set is not direct -> halt (R8)
    set_bits(1, 1, 1, 1);
    pulse_sleep();
    check("R8 medium req halts", cpu_halt, 1);
    check("R8 medium mode kept", mode, 1);
    pulse_wake();
    div_en = 1'b0; @(negedge clk);
    check("R2 high mode", mode, 0);
    check("R2 div sel off", sel_div_clk, 0);
  endtask

  task automatic go_sub();
    set_bits(1, 1, 1, 1);
    pulse_sleep();
  endtask

  task automatic t_down();
    do_reset();
    go_sub();
    check("R3 mode sub", mode, 2);
    check("R3 sub clk", sel_sub_clk, 1);
    check("R5 no halt down", cpu_halt, 0);
    check("R6 irq on down", xfer_irq, 1);
    @(negedge clk);
    check("R6 irq single", xfer_irq, 0);
  endtask

  // Sub -> high with settle code; optionally a stray request mid-wait (R10).
  task automatic t_up(input logic [2:0] code, input bit stray);
    int w;
    int bad_mode;
    int bad_halt;
    int bad_irq;
    w = 8 << code;
    bad_mode = 0; bad_halt = 0; bad_irq = 0;
    do_reset();
    go_sub();
    @(negedge clk);
    set_bits(1, 0, 1, 1);
    settle_sel = code;
    pulse_sleep();                   // edge 0 has acted
    for (int i = 1; i < w; i++) begin
      if (stray && i == 3) begin
        set_bits(0, 1, 0, 0);
        sleep_req = 1'b1;
      end else begin
        sleep_req = 1'b0;
      end
      if (mode != 2) bad_mode++;
      if (cpu_halt) bad_halt++;
      if (xfer_irq) bad_irq++;
      @(negedge clk);                // edge i has acted
    end
    sleep_req = 1'b0;
    if (mode != 2) bad_mode++;
    if (cpu_halt) bad_halt++;
    if (xfer_irq) bad_irq++;
    check(stray ? "R10 held sub" : "R4 held sub", bad_mode, 0);
    check(stray ? "R10 no halt" : "R5 no halt settle", bad_halt, 0);
    check("R6 no early irq", bad_irq, 0);
    @(negedge clk);                  // edge w has acted
    check("R4 mode high", mode, 0);
    check("R4 sub clk off", sel_sub_clk, 0);
    check("R6 irq on up", xfer_irq, 1);
    @(negedge clk);
    check("R6 irq drops", xfer_irq, 0);
  endtask

  task automatic t_no_dte();
    do_reset();
    set_bits(1, 1, 0, 1);
    pulse_sleep();
    check("R7 halt", cpu_halt, 1);
    check("R7 mode kept", mode, 0);
    check("R7 no irq", xfer_irq, 0);
    pulse_wake();
  endtask

  task automatic t_mismatch();
    do_reset();
    set_bits(0, 1, 1, 1); pulse_sleep();
    check("R8 stby=0 halt", cpu_halt, 1);
    pulse_wake();
    set_bits(1, 1, 1, 0); pulse_sleep();
    check("R8 psc=0 halt", cpu_halt, 1);
    check("R8 mode kept", mode, 0);
    pulse_wake();
    set_bits(1, 0, 1, 1); pulse_sleep();
    check("R8 lowspd=0 in high halt", cpu_halt, 1);
    pulse_wake();
    go_sub();
    @(negedge clk);
    set_bits(1, 1, 1, 1); pulse_sleep();
    check("R8 lowspd=1 in sub halt", cpu_halt, 1);
    check("R8 sub mode kept", mode, 2);
    pulse_wake();
  endtask

  task automatic t_wake();
    do_reset();
    pulse_wake();
    check("R9 wake ignored halt", cpu_halt, 0);
    check("R9 wake ignored mode", mode, 0);
    set_bits(1, 1, 0, 1); pulse_sleep();
    check("R9 halted", cpu_halt, 1);
    set_bits(1, 1, 1, 1); pulse_sleep();
    check("R9 sleep ignored in halt", cpu_halt, 1);
    check("R9 mode stays high", mode, 0);
    pulse_wake();
    check("R9 wake resumes", cpu_halt, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_medium();
    t_down();
    t_up(3'd0, 1'b0);
    t_up(3'd3, 1'b0);
    t_up(3'd7, 1'b0);
    t_up(3'd1, 1'b1);
    t_no_dte();
    t_mismatch();
    t_wake();
    done = 1'b1;
    finish_run();
  end
endmodule